// File: doc/BRIEF.md
# Endpoint-Zero Control and Status Register

This block holds the eight flag and command bits that firmware and the endpoint-zero packet engine use together to run control transfers. The CPU side is a plain register port: a read strobe, a write strobe, an endpoint index and one data byte each way. The packet engine side carries single-cycle event pulses into the block:

- a packet was received;
- the queued IN packet was transmitted;
- a STALL handshake went out;
- the control transaction ended;
- the status stage completed.

Three levels go back to the engine: IN packet queued, send a STALL, and data phase finished.

Each bit follows its own access rule. Some flags are set by hardware and cleared through separate write-one service bits. One flag is set by firmware and cleared by hardware. One flag is cleared by writing zero. The command bits clear themselves. The block merges the interrupt-worthy edges of the flags into a one-cycle interrupt pulse. No data flows through the block, so every pin is a plain control or status level, and there is no handshake and no back-pressure.

The register answers only when the index is zero. Events from the engine always take effect, whatever the index.

Top module: `ep0_ctl_reg`

## Requirements
- R1: After reset every flag is 0, `irq` is 0, and an index-zero read returns 0x00.
- R2: `ev_rx_pkt` sets the OUT-ready flag (bit 0). The flag is visible from the next cycle, and `irq` pulses in that same cycle if the flag was clear before.
- R3: An index-zero write with bit 6 set clears OUT-ready. Bits 6 and 7 always read 0. If `ev_rx_pkt` arrives in the same cycle as the clearing write, the flag stays set.
- R4: An index-zero write with bit 1 set sets IN-ready (bit 1, also driven on `in_ready`), and writing 0 to bit 1 has no effect. `ev_tx_done` clears IN-ready, and `irq` pulses on that falling edge.
- R5: `ev_stall_sent` sets the stall-sent flag (bit 2). An index-zero write with bit 2 at 0 clears it, and a write with bit 2 at 1 leaves it alone. The event wins over a clearing write in the same cycle.
- R6: An index-zero write with bit 3 set sets data-end (bit 3, also on `data_end`). `ev_status_done` or `ev_ctl_end` clears it, and hardware clearing wins over a firmware write in the same cycle.
- R7: `ev_ctl_end` sets setup-end (bit 4) only while data-end is 0, and `irq` pulses when setup-end rises. An index-zero write with bit 7 set clears setup-end. The event wins over a clearing write in the same cycle.
- R8: An index-zero write with bit 5 set drives `send_stall` (and read bit 5) high for exactly one cycle. After that cycle it returns to 0.
- R9: A write with a nonzero index changes nothing. A read with a nonzero index returns 0x00.
- R10: `irq` is high for one cycle per qualifying edge. Edges that happen in the same cycle give one single pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_idx | input | IDX_W | Endpoint index select; the register responds at 0 |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data; 0 unless reading at index 0 |
| ev_rx_pkt | input | 1 | Pulse: OUT data packet stored |
| ev_tx_done | input | 1 | Pulse: queued IN packet transmitted |
| ev_stall_sent | input | 1 | Pulse: STALL handshake transmitted |
| ev_ctl_end | input | 1 | Pulse: control transaction ended |
| ev_status_done | input | 1 | Pulse: status stage completed |
| in_ready | output | 1 | IN packet queued by firmware |
| send_stall | output | 1 | One-cycle request to answer with STALL |
| data_end | output | 1 | Firmware has finished the data phase |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that the event inputs are known after reset and that each event lasts one cycle. They also assume that the write check is disabled whenever an event or a pending stall command could legitimately move a flag. The stimulus changes inputs only on the falling clock edge and holds each event or strobe for one rising edge. It never raises the read and write strobes together. It places simultaneous event-and-write cycles deliberately, so that the priority rules are exercised inside these assumptions.

// File: rtl/ep0_csr_pkg.sv
package ep0_csr_pkg;
  localparam int unsigned CSR_W    = 8;
  localparam int unsigned B_OUTRDY = 0;
  localparam int unsigned B_INRDY  = 1;
  localparam int unsigned B_STLSNT = 2;
  localparam int unsigned B_DEND   = 3;
  localparam int unsigned B_SEND   = 4;
  localparam int unsigned B_STALL  = 5;
  localparam int unsigned B_SVCOUT = 6;
  localparam int unsigned B_SVCSE  = 7;
  // hardware-set flags held in the generic flag array
  localparam int unsigned NHW      = 3;
  localparam int unsigned HW_OUT   = 0;
  localparam int unsigned HW_STL   = 1;
  localparam int unsigned HW_SE    = 2;
endpackage

// File: rtl/ep0_hwflag.sv
module ep0_hwflag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic nxt_o,
  output logic q_o
);
  logic q;

  always_comb begin
    if (set_i)      nxt_o = 1'b1;
    else if (clr_i) nxt_o = 1'b0;
    else            nxt_o = q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= nxt_o;
  end

  assign q_o = q;

  // covers R3, R5, R7: a hardware set is never lost to a firmware clear
  p_set_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/ep0_irq_gen.sv
module ep0_irq_gen #(
  parameter int unsigned N         = 4,
  parameter logic [N-1:0] RISE_MSK = '0,
  parameter logic [N-1:0] FALL_MSK = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] cur_i,
  input  logic [N-1:0] nxt_i,
  output logic         irq_o
);
  logic [N-1:0] edge_v;
  logic         irq_q;

  for (genvar i = 0; i < N; i++) begin : g_edge
    if (RISE_MSK[i] && FALL_MSK[i]) begin : g_both
      assign edge_v[i] = nxt_i[i] ^ cur_i[i];
    end else if (RISE_MSK[i]) begin : g_rise
      assign edge_v[i] = nxt_i[i] & ~cur_i[i];
    end else if (FALL_MSK[i]) begin : g_fall
      assign edge_v[i] = ~nxt_i[i] & cur_i[i];
    end else begin : g_none
      assign edge_v[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |edge_v;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/ep0_ctl_reg.sv
module ep0_ctl_reg
  import ep0_csr_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_rd,
  input  logic             bus_wr,
  input  logic [IDX_W-1:0] bus_idx,
  input  logic [CSR_W-1:0] bus_wdata,
  output logic [CSR_W-1:0] bus_rdata,
  input  logic             ev_rx_pkt,
  input  logic             ev_tx_done,
  input  logic             ev_stall_sent,
  input  logic             ev_ctl_end,
  input  logic             ev_status_done,
  output logic             in_ready,
  output logic             send_stall,
  output logic             data_end,
  output logic             irq
);
  localparam int unsigned NIRQ = NHW + 1;
  localparam logic [NIRQ-1:0] RISE = NIRQ'((1 << HW_OUT) | (1 << HW_SE));
  localparam logic [NIRQ-1:0] FALL = NIRQ'(1 << NHW);

  logic sel, wr_en, rd_en;
  assign sel   = (bus_idx == '0);
  assign wr_en = bus_wr & sel;
  assign rd_en = bus_rd & sel;

  logic in_q, in_n, de_q, stall_q, se_set;
  logic [NHW-1:0] hw_set, hw_clr, hw_nxt, hw_q;

  assign se_set = ev_ctl_end & ~de_q;

  always_comb begin
    hw_set = '0;
    hw_clr = '0;
    hw_set[HW_OUT] = ev_rx_pkt;
    hw_clr[HW_OUT] = wr_en & bus_wdata[B_SVCOUT];
    hw_set[HW_STL] = ev_stall_sent;
    hw_clr[HW_STL] = wr_en & ~bus_wdata[B_STLSNT];
    hw_set[HW_SE]  = se_set;
    hw_clr[HW_SE]  = wr_en & bus_wdata[B_SVCSE];
  end

  for (genvar i = 0; i < NHW; i++) begin : g_flag
    ep0_hwflag u_flag (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (hw_set[i]),
      .clr_i (hw_clr[i]),
      .nxt_o (hw_nxt[i]),
      .q_o   (hw_q[i])
    );
  end

  // IN-ready: firmware set wins over transmit-done in the same cycle
  always_comb begin
    if (wr_en && bus_wdata[B_INRDY]) in_n = 1'b1;
    else if (ev_tx_done)             in_n = 1'b0;
    else                             in_n = in_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_q    <= 1'b0;
      de_q    <= 1'b0;
      stall_q <= 1'b0;
    end else begin
      in_q <= in_n;
      if (ev_status_done || ev_ctl_end)   de_q <= 1'b0;
      else if (wr_en && bus_wdata[B_DEND]) de_q <= 1'b1;
      stall_q <= !stall_q && wr_en && bus_wdata[B_STALL];
    end
  end

  ep0_irq_gen #(
    .N        (NIRQ),
    .RISE_MSK (RISE),
    .FALL_MSK (FALL)
  ) u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .cur_i ({in_q, hw_q}),
    .nxt_i ({in_n, hw_nxt}),
    .irq_o (irq)
  );

  logic [CSR_W-1:0] csr;
  always_comb begin
    csr           = '0;
    csr[B_OUTRDY] = hw_q[HW_OUT];
    csr[B_INRDY]  = in_q;
    csr[B_STLSNT] = hw_q[HW_STL];
    csr[B_DEND]   = de_q;
    csr[B_SEND]   = hw_q[HW_SE];
    csr[B_STALL]  = stall_q;
  end

  assign bus_rdata  = rd_en ? csr : '0;
  assign in_ready   = in_q;
  assign data_end   = de_q;
  assign send_stall = stall_q;

  p_out_irq_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rdata[B_OUTRDY] | hw_q[HW_OUT]) && !$past(hw_q[HW_OUT]) |-> irq);
  p_in_fall_irq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_ready) |-> irq);
  p_se_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_q[HW_SE]) |-> irq);
  p_de_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_status_done || ev_ctl_end) |=> !data_end);
  p_stall_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    send_stall |=> !send_stall);
  p_idx_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !sel && !ev_rx_pkt && !ev_tx_done && !ev_stall_sent &&
     !ev_ctl_end && !ev_status_done && !send_stall)
    |=> $stable({in_ready, data_end, send_stall, hw_q}));
  p_idx_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |-> (bus_rdata == '0));
  p_svc_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[B_SVCOUT] == 1'b0 && bus_rdata[B_SVCSE] == 1'b0);
endmodule

// File: tb/sim_ep0_ctl_reg.sv
module sim_ep0_ctl_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_rd = 0, bus_wr = 0;
  logic [3:0] bus_idx = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic ev_rx_pkt = 0, ev_tx_done = 0, ev_stall_sent = 0, ev_ctl_end = 0, ev_status_done = 0;
  logic in_ready, send_stall, data_end, irq;

  always #4 clk = ~clk;

  ep0_ctl_reg #(.IDX_W(4)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ev_rx_pkt(ev_rx_pkt),
    .ev_tx_done(ev_tx_done), .ev_stall_sent(ev_stall_sent), .ev_ctl_end(ev_ctl_end),
    .ev_status_done(ev_status_done), .in_ready(in_ready), .send_stall(send_stall),
    .data_end(data_end), .irq(irq)
  );

  typedef struct {
    logic [7:0] val;
    logic       irq;
    logic       idx0;
    string      tag;
  } exp_t;

  exp_t sb[$];
  int checks = 0;
  int errors = 0;
  bit done = 0;

  // monitor: samples 2 ns after each falling edge, away from the rising edge
  always @(negedge clk) begin
    #2;
    if (bus_rd && sb.size() > 0) begin
      exp_t e;
      logic [2:0] pins, pexp;
      e = sb.pop_front();
      checks++;
      if (bus_rdata !== e.val || irq !== e.irq) begin
        errors++;
        $display("FAIL %s rdata=%h irq=%b expected rdata=%h irq=%b",
                 e.tag, bus_rdata, irq, e.val, e.irq);
      end
      if (e.idx0) begin
        pins = {in_ready, send_stall, data_end};
        pexp = {e.val[1], e.val[5], e.val[3]};
        checks++;
        if (pins !== pexp) begin
          errors++;
          $display("FAIL %s pins=%b expected pins=%b", e.tag, pins, pexp);
        end
      end
    end
  end

  task automatic step(input logic [4:0] ev, input logic wr, input logic [3:0] idx,
                      input logic [7:0] wd);
    {ev_status_done, ev_ctl_end, ev_stall_sent, ev_tx_done, ev_rx_pkt} = ev;
    bus_wr = wr; bus_idx = idx; bus_wdata = wd;
    @(negedge clk);
    {ev_status_done, ev_ctl_end, ev_stall_sent, ev_tx_done, ev_rx_pkt} = '0;
    bus_wr = 0; bus_idx = '0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] idx, input logic [7:0] v, input logic i, input string tag);
    exp_t e;
    e.val = v; e.irq = i; e.idx0 = (idx == 0); e.tag = tag;
    sb.push_back(e);
    bus_rd = 1; bus_idx = idx;
    @(negedge clk);
    bus_rd = 0; bus_idx = '0;
  endtask

  localparam logic [4:0] RX = 5'b00001, TX = 5'b00010, SS = 5'b00100,
                         CE = 5'b01000, SD = 5'b10000, NO = 5'b00000;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, 8'h00, 0, "R1 reset state");
    // R2 / R10
    step(RX, 0, 0, 0);
    rd(0, 8'h01, 1, "R2 out-ready set with irq");
    rd(0, 8'h01, 0, "R10 irq lasts one cycle");
    // R3
    step(NO, 1, 0, 8'h40);
    rd(0, 8'h00, 0, "R3 service clears out-ready");
    step(RX, 0, 0, 0);
    rd(0, 8'h01, 1, "R2 out-ready set again");
    step(RX, 1, 0, 8'h40);
    rd(0, 8'h01, 0, "R3 hardware set wins over service");
    step(NO, 1, 0, 8'h40);
    rd(0, 8'h00, 0, "R3 cleared, service bits read 0");
    // R4
    step(NO, 1, 0, 8'h02);
    rd(0, 8'h02, 0, "R4 firmware sets in-ready");
    step(NO, 1, 0, 8'h00);
    rd(0, 8'h02, 0, "R4 writing 0 keeps in-ready");
    step(TX, 0, 0, 0);
    rd(0, 8'h00, 1, "R4 tx-done clears in-ready with irq");
    // R5
    step(SS, 0, 0, 0);
    rd(0, 8'h04, 0, "R5 stall-sent set");
    step(NO, 1, 0, 8'h04);
    rd(0, 8'h04, 0, "R5 writing 1 keeps stall-sent");
    step(SS, 1, 0, 8'h00);
    rd(0, 8'h04, 0, "R5 event wins over write-0");
    step(NO, 1, 0, 8'h00);
    rd(0, 8'h00, 0, "R5 write-0 clears stall-sent");
    // R6
    step(NO, 1, 0, 8'h08);
    rd(0, 8'h08, 0, "R6 data-end set");
    step(SD, 0, 0, 0);
    rd(0, 8'h00, 0, "R6 status done clears data-end");
    step(NO, 1, 0, 8'h08);
    step(CE, 0, 0, 0);
    rd(0, 8'h00, 0, "R6 R7 ctl-end with data-end: no setup-end");
    step(SD, 1, 0, 8'h08);
    rd(0, 8'h00, 0, "R6 hardware clear wins over write");
    // R7
    step(CE, 0, 0, 0);
    rd(0, 8'h10, 1, "R7 setup-end set with irq");
    step(NO, 1, 0, 8'h80);
    rd(0, 8'h00, 0, "R7 service clears setup-end");
    step(CE, 0, 0, 0);
    rd(0, 8'h10, 1, "R7 setup-end set again");
    step(CE, 1, 0, 8'h80);
    rd(0, 8'h10, 0, "R7 event wins over service");
    step(NO, 1, 0, 8'h80);
    rd(0, 8'h00, 0, "R7 setup-end cleared");
    // R8
    step(NO, 1, 0, 8'h20);
    rd(0, 8'h20, 0, "R8 send-stall high one cycle");
    rd(0, 8'h00, 0, "R8 send-stall cleared itself");
    // R9
    step(NO, 1, 4'd3, 8'h0A);
    rd(0, 8'h00, 0, "R9 nonzero-index write ignored");
    step(RX, 0, 0, 0);
    rd(4'd3, 8'h00, 1, "R9 nonzero-index read returns 0");
    rd(0, 8'h01, 0, "R9 state intact after other-index read");
    step(NO, 1, 0, 8'h40);
    // R10 merged edges
    step(NO, 1, 0, 8'h02);
    step(RX | TX, 0, 0, 0);
    rd(0, 8'h01, 1, "R10 simultaneous edges give one pulse");
    rd(0, 8'h01, 0, "R10 pulse ends after one cycle");
    repeat (2) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule